// File: doc/BRIEF.md
# Display Scan Line Address Generator

This block produces the display RAM line address that a matrix LCD refresh uses in each row period. A field-start pulse begins a field. Each row-period tick after that moves to the next row. The block reports two things for each row: which line of the RAM the segment drivers should read, and which COM electrode is being driven. The COM electrodes are always driven in ascending order, from index 0 up to the number of rows in the field minus one.

The RAM line address does not have to follow the COM order. It starts from a programmable start line and wraps modulo 128. A non-zero start line therefore scrolls the image up by that many rows. When row mirroring is on, the address starts at the far end of the field window and counts down, which flips the image upside down without touching the RAM.

The start line, the mirror flag and the 96/128 row select are taken only at field start, so the host can scroll on every field without tearing a frame. The row data is paced by the display timing and cannot stall. For that reason `row_valid` is a plain qualifier with no ready signal: the consumer must take the address in the cycle it is presented, and there is no back-pressure.

Top module: `scan_line_gen`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears `line_addr` and `com_idx` to 0, and `row_valid` and `field_done` to 0. The outputs stay idle until the next `field_start`.
- R2: With `mirror_en` low, the clock edge that samples `field_start` high sets `line_addr` to `start_line`, `com_idx` to 0 and `row_valid` to 1.
- R3: With mirroring off for the field, each accepted `row_tick` that is not on the last row sets `line_addr` to (previous + 1) mod 128, so 127 is followed by 0.
- R4: With `mirror_en` high at field start, the first `line_addr` is (`start_line` + rows − 1) mod 128. Rows is 96 when `mux_sel` is 0 and 128 when `mux_sel` is 1.
- R5: With mirroring on for the field, each accepted `row_tick` that is not on the last row sets `line_addr` to (previous − 1) mod 128, so 0 is followed by 127.
- R6: `com_idx` rises by exactly 1 on each accepted `row_tick`, starting from 0. This holds whatever the start line or mirror setting.
- R7: A field holds exactly rows row periods. A `row_tick` on the last row drops `row_valid` and raises `field_done` for exactly one clock, and `line_addr` and `com_idx` hold their values.
- R8: Changes to `start_line`, `mirror_en` or `mux_sel` during a field do not change that field's address sequence or its length.
- R9: A `row_tick` while `row_valid` is low has no effect on any output.
- R10: `field_start` takes priority over `row_tick` and restarts the field at once, even in the middle of a field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_start | input | 1 | One-cycle pulse that begins a field |
| row_tick | input | 1 | One-cycle pulse that ends the current row period |
| start_line | input | 7 | First RAM line of the field window |
| mirror_en | input | 1 | Row mirror: count the line address downward |
| mux_sel | input | 1 | Rows per field: 0 selects 96, 1 selects 128 |
| line_addr | output | 7 | RAM line address for the current row |
| com_idx | output | 7 | Binary index of the COM electrode being driven |
| row_valid | output | 1 | A row of the field is being presented |
| field_done | output | 1 | One-cycle strobe after the last row of a field |

## Verification
The hardest cases to reach are the two wrap points and the interaction between a field in progress and new configuration values. The wrap points are 127 to 0 when counting up and 0 to 127 when counting down. They appear only deep into a field, and only for certain start lines. The bench therefore runs whole fields with start lines of 120 and 100, which puts each wrap well inside the window. It also changes all three configuration inputs five rows into a field, and it pulses `field_start` together with `row_tick` while a field is running. A behavioural model is compared with the outputs on every cycle, so a wrong value at any single row is caught.

// File: rtl/scan_line_pkg.sv
package scan_line_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_ROW  = 1'b1
  } scan_state_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/scan_cfg_latch.sv
module scan_cfg_latch #(
  parameter int RW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic                    mirror_i,
  input  logic [RW-1:0]           rows_i,
  output scan_line_pkg::scan_dir_e dir_q,
  output logic [RW-1:0]           rows_q
);
  import scan_line_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= DIR_UP;
      rows_q <= rows_i;
    end else if (capture) begin
      dir_q  <= mirror_i ? DIR_DOWN : DIR_UP;
      rows_q <= rows_i;
    end
  end
endmodule

// File: rtl/scan_row_ctr.sv
module scan_row_ctr #(
  parameter int CNT_W = 7,
  parameter int RW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [RW-1:0]    rows_q,
  output logic             active,
  output logic [CNT_W-1:0] com_idx,
  output logic             at_last,
  output logic             step,
  output logic             field_done
);
  import scan_line_pkg::*;

  scan_state_e state;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(rows_q - RW'(1));
  assign active   = (state == SCAN_ROW);
  assign at_last  = (com_idx == last_idx);
  assign step     = tick && active && !start && !at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SCAN_IDLE;
      com_idx    <= '0;
      field_done <= 1'b0;
    end else begin
      field_done <= 1'b0;
      if (start) begin
        state   <= SCAN_ROW;
        com_idx <= '0;
      end else if (tick && active) begin
        if (at_last) begin
          state      <= SCAN_IDLE;
          field_done <= 1'b1;
        end else begin
          com_idx <= com_idx + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scan_line_addr.sv
module scan_line_addr #(
  parameter int ADDR_W = 7,
  parameter int RW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     step,
  input  logic [ADDR_W-1:0]        start_line,
  input  logic                     mirror_i,
  input  logic [RW-1:0]            rows_i,
  input  scan_line_pkg::scan_dir_e dir_q,
  output logic [ADDR_W-1:0]        line_addr
);
  import scan_line_pkg::*;

  logic [ADDR_W-1:0] first_fwd, first_rev, first_line, next_line;

  assign first_fwd  = start_line;
  assign first_rev  = start_line + ADDR_W'(rows_i - RW'(1));
  assign first_line = mirror_i ? first_rev : first_fwd;
  assign next_line  = (dir_q == DIR_DOWN) ? line_addr - ADDR_W'(1)
                                          : line_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)     line_addr <= '0;
    else if (start) line_addr <= first_line;
    else if (step)  line_addr <= next_line;
  end
endmodule

// File: rtl/scan_line_gen.sv
module scan_line_gen #(
  parameter int ADDR_W  = 7,
  parameter int ROWS_LO = 96,
  parameter int ROWS_HI = 128,
  localparam int CNT_W  = $clog2(ROWS_HI),
  localparam int RW     = $clog2(ROWS_HI + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              row_tick,
  input  logic [ADDR_W-1:0] start_line,
  input  logic              mirror_en,
  input  logic              mux_sel,
  output logic [ADDR_W-1:0] line_addr,
  output logic [CNT_W-1:0]  com_idx,
  output logic              row_valid,
  output logic              field_done
);
  import scan_line_pkg::*;

  logic [RW-1:0] rows_live, rows_q;
  scan_dir_e     dir_q;
  logic          cfg_mirror, at_last, step;

  assign rows_live  = mux_sel ? RW'(ROWS_HI) : RW'(ROWS_LO);
  assign cfg_mirror = (dir_q == DIR_DOWN);

  scan_cfg_latch #(.RW(RW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(field_start),
    .mirror_i(mirror_en), .rows_i(rows_live),
    .dir_q(dir_q), .rows_q(rows_q)
  );

  scan_row_ctr #(.CNT_W(CNT_W), .RW(RW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(field_start), .tick(row_tick),
    .rows_q(rows_q), .active(row_valid), .com_idx(com_idx),
    .at_last(at_last), .step(step), .field_done(field_done)
  );

  scan_line_addr #(.ADDR_W(ADDR_W), .RW(RW)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(field_start), .step(step),
    .start_line(start_line), .mirror_i(mirror_en), .rows_i(rows_live),
    .dir_q(dir_q), .line_addr(line_addr)
  );
endmodule

// File: rtl/scan_line_gen_chk.sv
module scan_line_gen_chk #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input logic              row_tick,
  input logic [ADDR_W-1:0] start_line,
  input logic              mirror_en,
  input logic [ADDR_W-1:0] line_addr,
  input logic [CNT_W-1:0]  com_idx,
  input logic              row_valid,
  input logic              field_done,
  input logic              cfg_mirror,
  input logic              at_last
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (line_addr == '0 && com_idx == '0 && !row_valid && !field_done));

  assert_first_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !mirror_en) |=> (line_addr == $past(start_line) && com_idx == '0 && row_valid));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_tick && !field_start && !at_last && !cfg_mirror)
      |=> line_addr == ADDR_W'($past(line_addr) + ADDR_W'(1)));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_tick && !field_start && !at_last && cfg_mirror)
      |=> line_addr == ADDR_W'($past(line_addr) - ADDR_W'(1)));

  assert_com_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_tick && !field_start && !at_last)
      |=> com_idx == CNT_W'($past(com_idx) + CNT_W'(1)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |=> !field_done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    field_done |-> !row_valid);

  assert_idle_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_valid && row_tick && !field_start)
      |=> ($stable(line_addr) && $stable(com_idx) && !row_valid));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (com_idx == '0 && row_valid));
endmodule

bind scan_line_gen scan_line_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .row_tick(row_tick),
  .start_line(start_line), .mirror_en(mirror_en), .line_addr(line_addr),
  .com_idx(com_idx), .row_valid(row_valid), .field_done(field_done),
  .cfg_mirror(cfg_mirror), .at_last(at_last)
);

// File: tb/scan_line_gen_bench.sv
module scan_line_gen_bench;
  localparam int CLK_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_start = 1'b0;
  logic       row_tick = 1'b0;
  logic [6:0] start_line = '0;
  logic       mirror_en = 1'b0;
  logic       mux_sel = 1'b0;
  logic [6:0] line_addr;
  logic [6:0] com_idx;
  logic       row_valid;
  logic       field_done;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  int m_act = 0, m_line = 0, m_com = 0, m_done = 0, m_rows = 96, m_mir = 0;

  always #(CLK_T/2) clk = ~clk;

  scan_line_gen u_scan_line_gen (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .row_tick(row_tick),
    .start_line(start_line), .mirror_en(mirror_en), .mux_sel(mux_sel),
    .line_addr(line_addr), .com_idx(com_idx), .row_valid(row_valid),
    .field_done(field_done)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_line = 0; m_com = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (field_start) begin
        m_rows = mux_sel ? 128 : 96;
        m_mir  = mirror_en;
        m_act  = 1;
        m_com  = 0;
        m_line = m_mir ? (int'(start_line) + m_rows - 1) % 128 : int'(start_line);
      end else if (row_tick && m_act == 1) begin
        if (m_com == m_rows - 1) begin
          m_act = 0; m_done = 1;
        end else begin
          m_com  = m_com + 1;
          m_line = m_mir ? (m_line + 127) % 128 : (m_line + 1) % 128;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_T/4);
    check({cur_req, " line_addr"}, int'(line_addr), m_line);
    check({cur_req, " com_idx"}, int'(com_idx), m_com);
    check({cur_req, " row_valid"}, int'(row_valid), m_act);
    check({cur_req, " field_done"}, int'(field_done), m_done);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(int sl, bit mir, bit mux, bit with_tick);
    @(negedge clk);
    start_line = 7'(sl); mirror_en = mir; mux_sel = mux;
    field_start = 1'b1; row_tick = with_tick;
    @(negedge clk);
    field_start = 1'b0; row_tick = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk) row_tick = 1'b1;
    @(negedge clk) row_tick = 1'b0;
  endtask

  // ticks until field_done; returns number of ticks taken
  task automatic ticks_to_end(int gap, bit perturb, int sl, bit mir, bit mux, output int n);
    n = 0;
    while (n < 300) begin
      tick_once();
      n++;
      if (field_done) break;
      if (perturb && n == 5) begin
        start_line = ~7'(sl); mirror_en = !mir; mux_sel = !mux;
      end
      idle(gap);
    end
  endtask

  task automatic run_field(int sl, bit mir, bit mux, int gap, bit perturb, string req);
    int rows, n;
    rows = mux ? 128 : 96;
    cur_req = req;
    pulse_start(sl, mir, mux, 1'b0);
    check({req, " first line"}, int'(line_addr), mir ? (sl + rows - 1) % 128 : sl);
    check({req, " first com"}, int'(com_idx), 0);
    ticks_to_end(gap, perturb, sl, mir, mux, n);
    check({"R7 rows per field ", req}, n, rows);
    check("R7 row_valid after field", int'(row_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    cur_req = "R1";
    idle(3);
    check("R1 reset line_addr", int'(line_addr), 0);
    check("R1 reset row_valid", int'(row_valid), 0);
    rst_n = 1'b1;

    cur_req = "R9";
    repeat (4) tick_once();
    check("R9 idle tick row_valid", int'(row_valid), 0);
    check("R9 idle tick com_idx", int'(com_idx), 0);

    run_field(0, 1'b0, 1'b0, 2, 1'b0, "R2+R3+R6");
    run_field(120, 1'b0, 1'b1, 1, 1'b0, "R3 wrap");
    run_field(10, 1'b1, 1'b0, 1, 1'b0, "R4");
    run_field(100, 1'b1, 1'b1, 0, 1'b0, "R5 wrap");
    run_field(33, 1'b0, 1'b0, 1, 1'b1, "R8 up");
    run_field(5, 1'b1, 1'b1, 0, 1'b1, "R8 down");

    cur_req = "R9";
    repeat (3) tick_once();
    check("R9 idle tick after field", int'(row_valid), 0);

    cur_req = "R10";
    pulse_start(50, 1'b0, 1'b1, 1'b0);
    repeat (10) tick_once();
    pulse_start(7, 1'b1, 1'b0, 1'b1);
    check("R10 restart line", int'(line_addr), 102);
    check("R10 restart com", int'(com_idx), 0);
    ticks_to_end(0, 1'b0, 7, 1'b1, 1'b0, n);
    check("R10 R7 rows after restart", n, 96);

    cur_req = "R1";
    pulse_start(20, 1'b0, 1'b0, 1'b0);
    repeat (5) tick_once();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-field reset line", int'(line_addr), 0);
    check("R1 mid-field reset com", int'(com_idx), 0);
    check("R1 mid-field reset valid", int'(row_valid), 0);
    rst_n = 1'b1;
    cur_req = "R9";
    repeat (2) tick_once();
    check("R9 tick after reset", int'(row_valid), 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule